// File: doc/BRIEF.md
# Relative Branch Cycle Accounting Unit

This block resolves one conditional relative branch for a 16-bit program counter. On a start strobe it samples the current program counter, an 8-bit signed displacement, a condition code, four status flags and a mode bit. It then decides whether the branch is taken, computes the branch target and the program counter that follows, and works out how many extra cycles the branch costs.

The target is always computed. The program counter moves to it only when the condition holds. A taken branch costs one extra cycle. In the legacy (emulation) mode, a second extra cycle is charged when the target lies in a different 256-byte page from the starting program counter. In native mode there is never a page penalty.

A small sequencer plays out the penalty. It shows each extra cycle as one cycle of `busy`, then pulses `done`, so that a surrounding core or a bench can stall for the exact count.

Top module: `rel_branch_timer`

## Requirements
- R1: On every accepted start, `target_pc` becomes `pc_in` plus the sign-extended `disp_in`, modulo 2^16, whether or not the branch is taken.
- R2: `cond_sel[2:1]` picks the flag: 00 = N (`flags_in[3]`), 01 = V (`flags_in[2]`), 10 = C (`flags_in[1]`), 11 = Z (`flags_in[0]`). `cond_sel[0]` = 1 branches when that flag is 1; `cond_sel[0]` = 0 branches when it is 0. `taken` shows the result.
- R3: A taken branch loads `pc_out` with `target_pc`. A branch not taken loads `pc_out` with `pc_in` and sets `extra_cycles` to 0.
- R4: With `emu_mode` = 0, a taken branch has `extra_cycles` = 1, even when the target is in another page.
- R5: With `emu_mode` = 1, a taken branch has `extra_cycles` = 2 when `target_pc[15:8]` differs from `pc_in[15:8]`, and 1 otherwise.
- R6: After the accepting edge, `busy` is high for exactly `extra_cycles` cycles and is followed by a single-cycle `done`. With 0 extra cycles, `done` comes in the first cycle after the accepting edge. `busy` and `done` are never high together.
- R7: A start while `busy` or `done` is high is ignored: `pc_out`, `target_pc`, `taken` and `extra_cycles` keep their values.
- R8: After reset, `pc_out`, `target_pc`, `taken`, `extra_cycles`, `busy` and `done` are all 0, and the unit accepts a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate a branch; accepted only when idle |
| pc_in | input | 16 | Program counter the branch is taken from |
| disp_in | input | 8 | Signed displacement |
| cond_sel | input | 3 | Flag select [2:1] and polarity [0] |
| flags_in | input | 4 | N, V, C, Z from bit 3 down to bit 0 |
| emu_mode | input | 1 | 1 = legacy mode with page-crossing penalty |
| pc_out | output | 16 | Program counter after the branch |
| target_pc | output | 16 | Computed branch target |
| taken | output | 1 | Condition held |
| extra_cycles | output | 2 | Penalty cycles charged (0..2) |
| busy | output | 1 | A penalty cycle is in progress |
| done | output | 1 | One-cycle end-of-branch pulse |

## Verification
The assertions check these on every cycle:
- `busy` and `done` never overlap, and `done` lasts one cycle.
- A branch not taken carries no penalty and leaves the program counter as sampled.
- A taken branch lands on the target.
- The target is the sampled program counter plus the sign-extended displacement.
- Native mode never charges more than one cycle.
- The results stay still when no start is accepted.

Only the bench's scenarios can show the rest. These are the full condition decode across all eight codes, the emulation-mode page decision in both wrap directions, and the exact number of `busy` cycles before `done`. They also include the rejection of a start that arrives during a penalty.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  // flag select code carried in cond_sel[2:1]
  typedef enum logic [1:0] {
    FSEL_NEG  = 2'd0,
    FSEL_OVF  = 2'd1,
    FSEL_CRY  = 2'd2,
    FSEL_ZERO = 2'd3
  } flag_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BUSY = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;

  localparam int unsigned NUM_FLAGS = 4;
endpackage

// File: rtl/rbr_cond_eval.sv
module rbr_cond_eval
  import rbr_pkg::*;
#(
  parameter int unsigned FLAG_W = NUM_FLAGS
) (
  input  logic [2:0]        cond_sel,
  input  logic [FLAG_W-1:0] flags,
  output logic              cond_true
);
  localparam int unsigned SEL_W = $clog2(FLAG_W);

  flag_sel_e sel;
  logic [FLAG_W-1:0] pick_vec;

  assign sel = flag_sel_e'(cond_sel[2:1]);

  // code 0 picks the top flag bit, code FLAG_W-1 the bottom one
  for (genvar g = 0; g < FLAG_W; g++) begin : g_pick
    assign pick_vec[g] = (sel == flag_sel_e'(SEL_W'(FLAG_W - 1 - g))) & flags[g];
  end

  assign cond_true = (|pick_vec) == cond_sel[0];
endmodule

// File: rtl/rbr_target_calc.sv
module rbr_target_calc #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned PAGE_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   target,
  output logic              page_cross
);
  localparam int unsigned EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  assign disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign target     = pc + disp_ext;
  assign page_cross = target[PC_W-1:PAGE_W] != pc[PC_W-1:PAGE_W];
endmodule

// File: rtl/rbr_seq.sv
module rbr_seq
  import rbr_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] pen_cycles,
  output logic             accept,
  output logic             busy,
  output logic             done
);
  seq_state_e state;
  logic [CNT_W-1:0] remain;

  assign accept = start && (state == SQ_IDLE) && !rst;
  assign busy   = state == SQ_BUSY;
  assign done   = state == SQ_DONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      remain <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (accept) begin
            remain <= pen_cycles;
            state  <= (pen_cycles == '0) ? SQ_DONE : SQ_BUSY;
          end
        end
        SQ_BUSY: begin
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= SQ_DONE;
        end
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rel_branch_timer.sv
module rel_branch_timer
  import rbr_pkg::*;
#(
  parameter int unsigned PC_W      = 16,
  parameter int unsigned DISP_W    = 8,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned TAKEN_PEN = 1,
  parameter int unsigned CROSS_PEN = 1,
  parameter int unsigned CNT_W     = $clog2(TAKEN_PEN + CROSS_PEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DISP_W-1:0] disp_in,
  input  logic [2:0]        cond_sel,
  input  logic [NUM_FLAGS-1:0] flags_in,
  input  logic              emu_mode,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   target_pc,
  output logic              taken,
  output logic [CNT_W-1:0]  extra_cycles,
  output logic              busy,
  output logic              done
);
  localparam logic [CNT_W-1:0] PEN_TAKEN = CNT_W'(TAKEN_PEN);
  localparam logic [CNT_W-1:0] PEN_CROSS = CNT_W'(CROSS_PEN);

  logic             cond_hit;
  logic [PC_W-1:0]  tgt_c;
  logic             cross_c;
  logic [CNT_W-1:0] pen_c;
  logic             accept;

  rbr_cond_eval #(.FLAG_W(NUM_FLAGS)) u_cond (
    .cond_sel  (cond_sel),
    .flags     (flags_in),
    .cond_true (cond_hit)
  );

  rbr_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W)) u_tgt (
    .pc         (pc_in),
    .disp       (disp_in),
    .target     (tgt_c),
    .page_cross (cross_c)
  );

  // page penalty applies only in legacy mode
  always_comb begin
    pen_c = '0;
    if (cond_hit) begin
      pen_c = PEN_TAKEN;
      if (emu_mode && cross_c) pen_c = PEN_TAKEN + PEN_CROSS;
    end
  end

  rbr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pen_cycles (pen_c),
    .accept     (accept),
    .busy       (busy),
    .done       (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out       <= '0;
      target_pc    <= '0;
      taken        <= 1'b0;
      extra_cycles <= '0;
    end else if (accept) begin
      target_pc    <= tgt_c;
      taken        <= cond_hit;
      pc_out       <= cond_hit ? tgt_c : pc_in;
      extra_cycles <= pen_c;
    end
  end
endmodule

// File: rtl/rbr_checker.sv
module rbr_checker #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              accept,
  input logic [PC_W-1:0]   pc_in,
  input logic [DISP_W-1:0] disp_in,
  input logic              emu_mode,
  input logic [PC_W-1:0]   pc_out,
  input logic [PC_W-1:0]   target_pc,
  input logic              taken,
  input logic [CNT_W-1:0]  extra_cycles,
  input logic              busy,
  input logic              done
);
  logic [PC_W-1:0] sext_disp;
  assign sext_disp = {{(PC_W-DISP_W){disp_in[DISP_W-1]}}, disp_in};

  AST_TARGET_SUM: assert property (@(posedge clk) disable iff (rst)
    $past(accept) |-> target_pc == $past(pc_in) + $past(sext_disp)); // R1
  AST_NT_PC_KEEP: assert property (@(posedge clk) disable iff (rst)
    ($past(accept) && !taken) |-> pc_out == $past(pc_in)); // R3
  AST_TK_PC_JUMP: assert property (@(posedge clk) disable iff (rst)
    ($past(accept) && taken) |-> pc_out == target_pc); // R3
  AST_NT_NO_PEN: assert property (@(posedge clk) disable iff (rst)
    !taken |-> extra_cycles == '0); // R3
  AST_NATIVE_ONE: assert property (@(posedge clk) disable iff (rst)
    ($past(accept) && !$past(emu_mode) && taken) |-> extra_cycles == CNT_W'(1)); // R4
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ($past(accept) && extra_cycles != '0) |-> busy); // R6
  AST_HOLD_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !$past(accept) |-> ($stable(pc_out) && $stable(target_pc) && $stable(extra_cycles))); // R7
endmodule

bind rel_branch_timer rbr_checker #(.PC_W(PC_W), .DISP_W(DISP_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .accept       (accept),
  .pc_in        (pc_in),
  .disp_in      (disp_in),
  .emu_mode     (emu_mode),
  .pc_out       (pc_out),
  .target_pc    (target_pc),
  .taken        (taken),
  .extra_cycles (extra_cycles),
  .busy         (busy),
  .done         (done)
);

// File: tb/tb_rel_branch_timer.sv
module tb_rel_branch_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  disp_in = '0;
  logic [2:0]  cond_sel = '0;
  logic [3:0]  flags_in = '0;
  logic        emu_mode = 1'b0;
  logic [15:0] pc_out, target_pc;
  logic        taken, busy, done;
  logic [1:0]  extra_cycles;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rel_branch_timer dut (
    .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .disp_in(disp_in),
    .cond_sel(cond_sel), .flags_in(flags_in), .emu_mode(emu_mode),
    .pc_out(pc_out), .target_pc(target_pc), .taken(taken),
    .extra_cycles(extra_cycles), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] f_target(input logic [15:0] p, input logic [7:0] d);
    return p + {{8{d[7]}}, d};
  endfunction

  function automatic logic f_cond(input logic [2:0] s, input logic [3:0] f);
    logic v;
    case (s[2:1])
      2'd0: v = f[3];
      2'd1: v = f[2];
      2'd2: v = f[1];
      default: v = f[0];
    endcase
    return v == s[0];
  endfunction

  function automatic logic [1:0] f_extra(input logic tk, input logic emu,
                                         input logic [15:0] p, input logic [15:0] t);
    if (!tk) return 2'd0;
    if (emu && (p[15:8] != t[15:8])) return 2'd2;
    return 2'd1;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
    end
  endtask

  // drive one branch, then watch the penalty; poke = push starts during it
  task automatic run_branch(input logic [15:0] p, input logic [7:0] d,
                            input logic [2:0] s, input logic [3:0] f,
                            input logic emu, input logic poke);
    logic [15:0] et;
    logic        ek;
    logic [1:0]  ex;
    int          nbusy;
    et = f_target(p, d);
    ek = f_cond(s, f);
    ex = f_extra(ek, emu, p, et);
    pc_in = p; disp_in = d; cond_sel = s; flags_in = f; emu_mode = emu;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(target_pc == et, "R1 target", target_pc, et);
    check(taken == ek, "R2 taken", taken, ek);
    check(pc_out == (ek ? et : p), "R3 pc_out", pc_out, ek ? et : p);
    if (!emu) check(extra_cycles == ex, "R4 native extra", extra_cycles, ex);
    else      check(extra_cycles == ex, "R5 emu extra", extra_cycles, ex);
    nbusy = 0;
    for (int i = 0; i < 6 && !done; i++) begin
      if (busy) nbusy++;
      if (poke) begin
        pc_in = ~p; disp_in = ~d; cond_sel = ~s; flags_in = ~f; emu_mode = ~emu;
        start = 1'b1;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(done && !busy, "R6 done pulse", {busy, done}, 2'b01);
    check(nbusy == int'(ex), "R6 busy count", nbusy, ex);
    if (poke) begin
      check(pc_out == (ek ? et : p) && target_pc == et && extra_cycles == ex,
            "R7 ignored start", pc_out, ek ? et : p);
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(pc_out == 0 && target_pc == 0 && !taken && extra_cycles == 0 && !busy && !done,
          "R8 reset", {pc_out, target_pc}, 0);

    // R4 native taken across a page: one cycle only
    run_branch(16'h12F0, 8'h20, 3'b001, 4'b1000, 1'b0, 1'b0);
    // R5 emulation taken across a page
    run_branch(16'h12F0, 8'h20, 3'b001, 4'b1000, 1'b1, 1'b0);
    // R5 emulation taken inside the page
    run_branch(16'h1210, 8'h20, 3'b110, 4'b0000, 1'b1, 1'b0);
    // R1 backward wrap below zero, emulation
    run_branch(16'h0005, 8'h80, 3'b111, 4'b0001, 1'b1, 1'b0);
    // R1 forward wrap above 0xFFFF
    run_branch(16'hFFF0, 8'h7F, 3'b011, 4'b0100, 1'b1, 1'b0);
    // R3 not taken with a crossing target: no penalty, pc kept
    run_branch(16'h12F0, 8'h20, 3'b101, 4'b0000, 1'b1, 1'b0);
    // R2 all eight conditions against both flag values
    for (int c = 0; c < 8; c++) begin
      run_branch(16'h4000, 8'h04, 3'(c), 4'b1111, 1'b0, 1'b0);
      run_branch(16'h4000, 8'h04, 3'(c), 4'b0000, 1'b0, 1'b0);
    end
    // R7 starts during penalty of 2, of 1 and of 0 cycles
    run_branch(16'h30FF, 8'h01, 3'b001, 4'b1000, 1'b1, 1'b1);
    run_branch(16'h3080, 8'h01, 3'b001, 4'b1000, 1'b1, 1'b1);
    run_branch(16'h3080, 8'h01, 3'b000, 4'b1000, 1'b1, 1'b1);
    // random mix
    for (int n = 0; n < 400; n++) begin
      run_branch(16'($urandom), 8'($urandom), 3'($urandom), 4'($urandom),
                 1'($urandom), ($urandom % 8) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule